// File: doc/BRIEF.md
# Four-Output PWM Group Generator

This block drives four pulse-width outputs, arranged as two pairs, from one shared period counter. The counter either ramps up and wraps, giving edge-aligned pulses, or ramps up and then back down, giving center-aligned pulses. Each pair can run as two independent channels, or as a primary output and its logical complement.

Software-side logic programs the block through a small write port. Every write lands in a shadow register. The period and the mode bits move into the active copies only at the start of a period. The duty values move at the start of a period, and in center-aligned double-update mode they also move at the midpoint, so the rising and falling halves of a pulse can differ. Two one-cycle strobes mark the period start and the midpoint reload, so neighbouring logic can align to them.

Top module: `pwm_quad_gen`

## Requirements
- R1: With mode bit 0 clear (edge-aligned), the count runs 0,1,…,P-1 and then wraps, so a period lasts P cycles. Output n is high in the cycles where the count is below its active duty value.
- R2: With mode bit 0 set (center-aligned), a period lasts 2P cycles. The count rises 0…P-1 in the first half and falls P-1…0 in the second half. Output n is high while the count is below the duty value active in that half.
- R3: A duty value of 0 holds the raw channel low for the whole period. A duty value equal to or above P holds it high for the whole period.
- R4: Mode bit 2 pairs outputs 0 and 1, and mode bit 3 pairs outputs 2 and 3. In a paired pair the odd output is the complement of the even one and its own duty value has no effect. With the bit clear, both outputs follow their own duty values.
- R5: Outside double-update mode, duty writes made during a period have no effect on that period. They apply from the next period start.
- R6: With mode bits 0 and 1 both set, the shadow duty values are also loaded at the midpoint, and the second half of that period uses them. mid_pulse is high for one cycle in the first cycle of the second half.
- R7: start_pulse is high for exactly one cycle, the first cycle of every period. mid_pulse never coincides with it and stays low unless double-update center mode is active.
- R8: Write addresses are: 0 for the period, 1–4 for the duty values of outputs 0–3, and 5 for the mode bits (bit 0 center, bit 1 double update, bits 2/3 pairing). A period value of 0 acts as 1. The period and the mode bits take effect only at a period start.
- R9: Synchronous reset clears all shadow and active registers and starts a period at count 0. In the first cycle after reset the outputs are low and start_pulse is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register select |
| wr_data | input | CNT_W | Write value |
| pwm_out | output | 4 | PWM outputs, two pairs |
| start_pulse | output | 1 | Period start strobe |
| mid_pulse | output | 1 | Midpoint reload strobe |

## Verification
The checker assumes that reset is applied before the first clock. It also treats the active registers as able to change only at the cycle edge that opens a period or a midpoint, which rests on the write port reaching only the shadow copies.

The bench avoids the one ambiguous case, a write that lands on the same edge as a reload. It waits for a fresh start strobe after each batch of writes. It also uses periods of at least six so that writes made during a period finish before the midpoint edge.

// File: rtl/pwm_pkg.sv
`timescale 1ns/1ps
package pwm_pkg;
    localparam int NUM_CH    = 4;
    localparam int NUM_PAIRS = NUM_CH / 2;
    localparam int ADDR_W    = 3;

    typedef enum logic [ADDR_W-1:0] {
        RA_PERIOD = 3'd0,
        RA_DUTY0  = 3'd1,
        RA_DUTY1  = 3'd2,
        RA_DUTY2  = 3'd3,
        RA_DUTY3  = 3'd4,
        RA_MODE   = 3'd5
    } reg_addr_e;

    // bit 0 center, bit 1 double update, bits 2/3 pairing
    typedef struct packed {
        logic pair_b;
        logic pair_a;
        logic dbl;
        logic center;
    } mode_t;

    localparam int MODE_W = $bits(mode_t);

    function automatic logic [NUM_CH-1:0] apply_pairing(
        input logic [NUM_CH-1:0]    raw,
        input logic [NUM_PAIRS-1:0] paired
    );
        logic [NUM_CH-1:0] res;
        res = raw;
        for (int p = 0; p < NUM_PAIRS; p++) begin
            if (paired[p]) res[2*p+1] = ~raw[2*p];
        end
        return res;
    endfunction
endpackage

// File: rtl/pwm_regs.sv
`timescale 1ns/1ps
module pwm_regs
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic                              clk,
    input  logic                              rst,
    input  logic                              wr_en,
    input  logic [ADDR_W-1:0]                 wr_addr,
    input  logic [CNT_W-1:0]                  wr_data,
    input  logic                              ld_full,
    input  logic                              ld_mid,
    output logic [CNT_W-1:0]                  per_act,
    output mode_t                             mode_act,
    output logic [NUM_CH-1:0][CNT_W-1:0]      duty_act
);
    logic [CNT_W-1:0]             per_sh;
    mode_t                        mode_sh;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_sh;
    reg_addr_e                    sel;

    always_comb sel = reg_addr_e'(wr_addr);

    always_ff @(posedge clk) begin
        if (rst) begin
            per_sh  <= '0;
            mode_sh <= '0;
            duty_sh <= '0;
        end else if (wr_en) begin
            case (sel)
                RA_PERIOD: per_sh  <= wr_data;
                RA_MODE:   mode_sh <= mode_t'(wr_data[MODE_W-1:0]);
                RA_DUTY0:  duty_sh[0] <= wr_data;
                RA_DUTY1:  duty_sh[1] <= wr_data;
                RA_DUTY2:  duty_sh[2] <= wr_data;
                RA_DUTY3:  duty_sh[3] <= wr_data;
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            per_act  <= '0;
            mode_act <= '0;
            duty_act <= '0;
        end else if (ld_full) begin
            per_act  <= per_sh;
            mode_act <= mode_sh;
            duty_act <= duty_sh;
        end else if (ld_mid) begin
            duty_act <= duty_sh;
        end
    end
endmodule

// File: rtl/pwm_timebase.sv
`timescale 1ns/1ps
module pwm_timebase #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] per_act,
    input  logic             center,
    input  logic             dbl,
    output logic [CNT_W-1:0] cnt,
    output logic             at_start,
    output logic             at_mid,
    output logic             ld_full,
    output logic             ld_mid
);
    logic             up;
    logic [CNT_W-1:0] top_val;
    logic             at_top;

    always_comb begin
        top_val  = (per_act == '0) ? '0 : per_act - 1'b1;
        at_top   = (cnt == top_val);
        ld_full  = center ? (!up && cnt == '0) : at_top;
        ld_mid   = center && dbl && up && at_top;
        at_start = up && cnt == '0;
        at_mid   = center && dbl && !up && at_top;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (ld_full) begin
            cnt <= '0;
            up  <= 1'b1;
        end else if (center) begin
            if (up) begin
                if (at_top) up  <= 1'b0;
                else        cnt <= cnt + 1'b1;
            end else begin
                cnt <= cnt - 1'b1;
            end
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/pwm_chan_cmp.sv
`timescale 1ns/1ps
module pwm_chan_cmp #(
    parameter int CNT_W = 16
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] duty,
    output logic             hi
);
    always_comb hi = (cnt < duty);
endmodule

// File: rtl/pwm_quad_gen.sv
`timescale 1ns/1ps
module pwm_quad_gen
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [CNT_W-1:0]   wr_data,
    output logic [NUM_CH-1:0]  pwm_out,
    output logic               start_pulse,
    output logic               mid_pulse
);
    logic [CNT_W-1:0]             per_act;
    mode_t                        mode_act;
    logic [NUM_CH-1:0][CNT_W-1:0] duty_act;
    logic [CNT_W-1:0]             cnt;
    logic                         ld_full, ld_mid;
    logic [NUM_CH-1:0]            raw_hi;

    pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .ld_full  (ld_full),
        .ld_mid   (ld_mid),
        .per_act  (per_act),
        .mode_act (mode_act),
        .duty_act (duty_act)
    );

    pwm_timebase #(.CNT_W(CNT_W)) u_tb (
        .clk      (clk),
        .rst      (rst),
        .per_act  (per_act),
        .center   (mode_act.center),
        .dbl      (mode_act.dbl),
        .cnt      (cnt),
        .at_start (start_pulse),
        .at_mid   (mid_pulse),
        .ld_full  (ld_full),
        .ld_mid   (ld_mid)
    );

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
        pwm_chan_cmp #(.CNT_W(CNT_W)) u_cmp (
            .cnt  (cnt),
            .duty (duty_act[ch]),
            .hi   (raw_hi[ch])
        );
    end

    always_comb pwm_out = apply_pairing(raw_hi, {mode_act.pair_b, mode_act.pair_a});
endmodule

// File: rtl/pwm_quad_chk.sv
`timescale 1ns/1ps
module pwm_quad_chk
    import pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input logic                         clk,
    input logic                         rst,
    input logic [NUM_CH-1:0]            pwm_out,
    input logic                         start_pulse,
    input logic                         mid_pulse,
    input logic [CNT_W-1:0]             cnt,
    input logic [CNT_W-1:0]             per_act,
    input mode_t                        mode_act,
    input logic [NUM_CH-1:0][CNT_W-1:0] duty_act
);
    logic [CNT_W-1:0] eff_per;
    always_comb eff_per = (per_act == '0) ? CNT_W'(1) : per_act;

    a_r7_pulse_excl: assert property (@(posedge clk) disable iff (rst)
        !(start_pulse && mid_pulse));

    a_r6_mid_needs_dbl: assert property (@(posedge clk) disable iff (rst)
        mid_pulse |-> (mode_act.center && mode_act.dbl));

    a_r1_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
        cnt < eff_per);

    a_r5_duty_hold: assert property (@(posedge clk) disable iff (rst)
        (!start_pulse && !mid_pulse) |-> $stable(duty_act));

    a_r8_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        !start_pulse |-> ($stable(per_act) && $stable(mode_act)));

    a_r3_zero_low: assert property (@(posedge clk) disable iff (rst)
        (duty_act[0] == '0) |-> !pwm_out[0]);

    a_r3_full_high: assert property (@(posedge clk) disable iff (rst)
        (duty_act[2] >= eff_per) |-> pwm_out[2]);
endmodule

bind pwm_quad_gen pwm_quad_chk #(.CNT_W(CNT_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .pwm_out     (pwm_out),
    .start_pulse (start_pulse),
    .mid_pulse   (mid_pulse),
    .cnt         (cnt),
    .per_act     (per_act),
    .mode_act    (mode_act),
    .duty_act    (duty_act)
);

// File: tb/sim_pwm_quad_gen.sv
`timescale 1ns/1ps
module sim_pwm_quad_gen;
    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         wr_en = 1'b0;
    logic [2:0]   wr_addr = '0;
    logic [W-1:0] wr_data = '0;
    logic [3:0]   pwm_out;
    logic         start_pulse, mid_pulse;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;

    always #2.5 clk = ~clk;

    pwm_quad_gen #(.CNT_W(W)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .pwm_out(pwm_out),
        .start_pulse(start_pulse), .mid_pulse(mid_pulse)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            bad++;
            total++;
            $display("FAIL watchdog: run hung, actual=%0d cycles expected<150000", cyc);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input int k, input logic [5:0] act, input logic [5:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s k=%0d actual(mid,start,out)=%b expected=%b", tag, k, act, exp);
        end
    endtask

    task automatic wr(input int a, input int v);
        @(negedge clk);
        wr_en   = 1'b1;
        wr_addr = 3'(a);
        wr_data = W'(v);
        @(negedge clk);
        wr_en   = 1'b0;
    endtask

    task automatic wait_start();
        int n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!start_pulse && n < 1000);
    endtask

    function automatic logic [5:0] expect_at(input int k, input bit ctr, input bit dbl,
                                             input bit [1:0] pm, input int p,
                                             input int d[4], input int d2[4]);
        logic [3:0] raw, o;
        int pos, dd;
        bit second;
        second = ctr && (k >= p);
        pos    = second ? (2*p - 1 - k) : k;
        for (int i = 0; i < 4; i++) begin
            dd = (ctr && dbl && second) ? d2[i] : d[i];
            raw[i] = (pos < dd);
        end
        o = raw;
        if (pm[0]) o[1] = ~raw[0];
        if (pm[1]) o[3] = ~raw[2];
        return {(ctr && dbl && k == p), (k == 0), o};
    endfunction

    task automatic run_cfg(input bit ctr, input bit dbl, input bit [1:0] pm,
                           input int p, input int seed);
        int d[4];
        int d2[4];
        int len;
        string tag;
        for (int i = 0; i < 4; i++) begin
            d[i]  = (i*3 + seed*2) % (p + 2);
            d2[i] = (i*5 + seed + 1) % (p + 2);
        end
        if (!ctr)     tag = "R1 R3 R4 R5 R7 R8";
        else if (dbl) tag = "R2 R3 R4 R6 R7 R8";
        else          tag = "R2 R3 R4 R5 R7 R8";
        wr(0, p);
        wr(5, int'(ctr) | (int'(dbl) << 1) | (int'(pm) << 2));
        for (int i = 0; i < 4; i++) wr(1 + i, d[i]);
        wait_start();
        len = ctr ? 2*p : p;
        for (int k = 0; k < len; k++) begin
            if (k > 0) @(negedge clk);
            chk(tag, k, {mid_pulse, start_pulse, pwm_out}, expect_at(k, ctr, dbl, pm, p, d, d2));
            // mid-period shadow writes: used at midpoint only in double mode (R5, R6)
            if (k < 4) begin
                wr_en   = 1'b1;
                wr_addr = 3'(k + 1);
                wr_data = W'(d2[k]);
            end else begin
                wr_en = 1'b0;
            end
        end
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset state, period acts as 1 so every cycle starts a period
        chk("R9", 0, {mid_pulse, start_pulse, pwm_out}, 6'b010000);

        for (int m = 0; m < 3; m++)
            for (int pm = 0; pm < 4; pm++)
                for (int pi = 0; pi < 2; pi++)
                    for (int s = 0; s < 4; s++)
                        run_cfg(m != 0, m == 2, 2'(pm), (pi == 0) ? 6 : 9, s);

        // R8: period value 0 behaves as period 1
        wr(0, 0);
        wr(5, 0);
        wr(1, 1); wr(2, 0); wr(3, 1); wr(4, 0);
        wait_start();
        wait_start();
        for (int k = 0; k < 4; k++) begin
            @(negedge clk);
            chk("R8", k, {mid_pulse, start_pulse, pwm_out}, 6'b010101);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule